// File: doc/BRIEF.md
# Same-Privilege Interrupt Entry Frame Sequencer

This block performs the stack part of a software interrupt entry that keeps the current privilege level. A request carries an entry form and an 8-bit immediate, together with a snapshot of machine state: flags, return code selector and pointer, stack pointer and stack limit, and the gate's target selector, pointer and segment limit. The block resolves the vector number. It then checks that the stack has room for the whole frame and that the target pointer lies inside the target segment.

If both checks pass, it pushes the frame through a memory write port that takes one word per cycle. The stack grows downward. After the frame it produces the new flags, stack pointer, code selector and code pointer. If a check fails, the block raises exactly one fault, writes nothing to memory and leaves the published register values untouched. The surrounding pipeline holds the snapshot steady for the cycle the request is sampled in. It watches `done_o` to learn the outcome.

Top module: `int_frame_seq`

## Requirements
- R1: `vector_o` is 3 for form 1 (breakpoint), 4 for form 2 (overflow trap) and `imm_i` for form 0 (immediate vector). It is captured when the request is accepted.
- R2: With `gate32_i`=1 the frame needs 16 bytes when `has_err_i`=1 and 12 bytes otherwise. If `sp_i` < `sp_limit_i` + need, the block raises `ss_fault_o`, performs no memory write and leaves `sp_o`, `flags_o`, `cs_o` and `ip_o` unchanged.
- R3: With `gate32_i`=0 the frame needs 8 bytes with an error code and 6 bytes without one. A shortfall behaves as described in R2.
- R4: The frame is written in this order: flags, return selector, return pointer, then the error code if `has_err_i`=1. The stack pointer is decremented by one slot before each write, so the first write goes to `sp_i` − slot.
- R5: A 32-bit gate uses 4-byte slots with `mem_wide_o`=1. The return selector is zero-extended to 32 bits.
- R6: A 16-bit gate uses 2-byte slots with `mem_wide_o`=0. Each slot value is the low 16 bits of its source, zero-extended on `mem_wdata_o`.
- R7: On success `sp_o` = `sp_i` − frame size. `ip_o` is the target pointer (its low 16 bits for a 16-bit gate). `cs_o` is `tgt_cs_i` with bits [1:0] replaced by `cpl_i`.
- R8: On success `flags_o` is `flags_i` with bits 8, 14, 16 and 17 cleared. Bit 9 is cleared only when `gate_intr_i`=1; for a trap gate it is kept.
- R9: If `tgt_ip_i` > `tgt_limit_i` and the stack has room, the block raises `gp_fault_o` and performs no write. When both checks fail, only `ss_fault_o` is raised.
- R10: `busy_o` is high from the cycle after acceptance until `done_o`. `done_o` lasts one cycle. It comes 2 cycles after acceptance on a fault and N+2 cycles after acceptance on success, where N is the slot count. A fault output is high only together with `done_o`.
- R11: `req_i` and the snapshot inputs are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Entry request, sampled when idle |
| form_i | input | 2 | 0 immediate vector, 1 breakpoint, 2 overflow trap |
| imm_i | input | 8 | Immediate vector |
| gate32_i | input | 1 | 1 for a 32-bit gate, 0 for a 16-bit gate |
| gate_intr_i | input | 1 | 1 for an interrupt gate, 0 for a trap gate |
| has_err_i | input | 1 | An error code is pushed |
| err_code_i | input | 32 | Error code value |
| sp_i | input | 32 | Current stack pointer |
| sp_limit_i | input | 32 | Lowest usable stack address |
| flags_i | input | 32 | Current flags |
| cs_i | input | 16 | Return code selector |
| ip_i | input | 32 | Return pointer |
| tgt_cs_i | input | 16 | Gate target selector |
| tgt_ip_i | input | 32 | Gate target pointer |
| tgt_limit_i | input | 32 | Target segment limit |
| cpl_i | input | 2 | Current privilege level |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ss_fault_o | output | 1 | Stack fault (error code 0), with done |
| gp_fault_o | output | 1 | Protection fault (error code 0), with done |
| vector_o | output | 8 | Resolved vector number |
| mem_we_o | output | 1 | Frame write strobe |
| mem_wide_o | output | 1 | 1 for a 4-byte write, 0 for a 2-byte write |
| mem_addr_o | output | 32 | Write address |
| mem_wdata_o | output | 32 | Write data |
| sp_o | output | 32 | Updated stack pointer |
| flags_o | output | 32 | Updated flags |
| cs_o | output | 16 | Updated code selector |
| ip_o | output | 32 | Updated code pointer |

## Verification
The hardest case to reach is the exact edge of the room check: a stack limit that leaves exactly the required bytes must pass, and one byte less must fault. For each gate size and error-code choice, the bench computes the limit as the current pointer minus the needed byte count, then moves it up by one. It also pairs that edge with an out-of-limit target to exercise the priority between the two faults. A further run holds `req_i` high and alters the snapshot while the sequencer is busy. That run confirms that neither the frame nor the vector changes.

// File: rtl/int_frame_pkg.sv
package int_frame_pkg;
  typedef enum logic [1:0] {FORM_IMM = 2'd0, FORM_BRK = 2'd1, FORM_OVF = 2'd2} form_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_PUSH} state_e;
  typedef enum logic [1:0] {SLOT_FLAGS, SLOT_SEL, SLOT_PTR, SLOT_ERR} slot_e;

  localparam int TRAP_BIT   = 8;
  localparam int IEN_BIT    = 9;
  localparam int NEST_BIT   = 14;
  localparam int RESUME_BIT = 16;
  localparam int V86_BIT    = 17;
  localparam int BASE_SLOTS = 3;
  localparam logic [7:0] VEC_BRK = 8'd3;
  localparam logic [7:0] VEC_OVF = 8'd4;
endpackage

// File: rtl/ifs_room_check.sv
module ifs_room_check #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] sp_limit_i,
  input  logic          gate32_i,
  input  logic          has_err_i,
  input  logic [AW-1:0] tgt_ip_i,
  input  logic [AW-1:0] tgt_limit_i,
  output logic          ss_fault_o,
  output logic          gp_fault_o
);
  import int_frame_pkg::*;

  logic [AW:0] slot_bytes;
  logic [AW:0] need;
  logic [AW:0] floor_addr;

  always_comb begin
    slot_bytes = gate32_i ? (AW+1)'(4) : (AW+1)'(2);
    need       = slot_bytes * (AW+1)'(BASE_SLOTS + int'(has_err_i));
    floor_addr = {1'b0, sp_limit_i} + need;
    ss_fault_o = {1'b0, sp_i} < floor_addr;
    // stack shortfall takes priority over the target limit
    gp_fault_o = !ss_fault_o && (tgt_ip_i > tgt_limit_i);
  end
endmodule

// File: rtl/ifs_slot_mux.sv
module ifs_slot_mux #(
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  int_frame_pkg::slot_e slot_i,
  input  logic                 gate32_i,
  input  logic [DW-1:0]        flags_i,
  input  logic [SW-1:0]        cs_i,
  input  logic [DW-1:0]        ip_i,
  input  logic [DW-1:0]        err_i,
  output logic [DW-1:0]        data_o
);
  import int_frame_pkg::*;

  logic [DW-1:0] raw;

  always_comb begin
    unique case (slot_i)
      SLOT_FLAGS: raw = flags_i;
      SLOT_SEL:   raw = DW'(cs_i);
      SLOT_PTR:   raw = ip_i;
      default:    raw = err_i;
    endcase
    data_o = gate32_i ? raw : {{(DW-16){1'b0}}, raw[15:0]};
  end
endmodule

// File: rtl/ifs_flag_update.sv
module ifs_flag_update #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] flags_i,
  input  logic          gate_intr_i,
  output logic [DW-1:0] flags_o
);
  import int_frame_pkg::*;

  logic [DW-1:0] clr;

  always_comb begin
    clr = '0;
    clr[TRAP_BIT]   = 1'b1;
    clr[NEST_BIT]   = 1'b1;
    clr[RESUME_BIT] = 1'b1;
    clr[V86_BIT]    = 1'b1;
    clr[IEN_BIT]    = gate_intr_i;
    flags_o = flags_i & ~clr;
  end
endmodule

// File: rtl/int_frame_seq.sv
module int_frame_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    form_i,
  input  logic [7:0]    imm_i,
  input  logic          gate32_i,
  input  logic          gate_intr_i,
  input  logic          has_err_i,
  input  logic [DW-1:0] err_code_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] sp_limit_i,
  input  logic [DW-1:0] flags_i,
  input  logic [SW-1:0] cs_i,
  input  logic [AW-1:0] ip_i,
  input  logic [SW-1:0] tgt_cs_i,
  input  logic [AW-1:0] tgt_ip_i,
  input  logic [AW-1:0] tgt_limit_i,
  input  logic [1:0]    cpl_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ss_fault_o,
  output logic          gp_fault_o,
  output logic [7:0]    vector_o,
  output logic          mem_we_o,
  output logic          mem_wide_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] sp_o,
  output logic [DW-1:0] flags_o,
  output logic [SW-1:0] cs_o,
  output logic [AW-1:0] ip_o
);
  import int_frame_pkg::*;

  state_e        state_q;
  slot_e         slot_q;
  logic          g32_q, intr_q, err_q;
  logic [DW-1:0] err_code_q, flags_q;
  logic [AW-1:0] sp_q, lim_q, ip_q, tgt_ip_q, tgt_lim_q;
  logic [SW-1:0] cs_q, tgt_cs_q;
  logic [1:0]    cpl_q;

  logic          chk_ss, chk_gp;
  logic [DW-1:0] slot_data, flags_new;
  logic [AW-1:0] slot_step, sp_next;
  logic          last_slot;
  logic [7:0]    vec_sel;

  ifs_room_check #(.AW(AW)) i_room (
    .sp_i(sp_q), .sp_limit_i(lim_q), .gate32_i(g32_q), .has_err_i(err_q),
    .tgt_ip_i(tgt_ip_q), .tgt_limit_i(tgt_lim_q),
    .ss_fault_o(chk_ss), .gp_fault_o(chk_gp)
  );

  ifs_slot_mux #(.DW(DW), .SW(SW)) i_mux (
    .slot_i(slot_q), .gate32_i(g32_q), .flags_i(flags_q), .cs_i(cs_q),
    .ip_i(DW'(ip_q)), .err_i(err_code_q), .data_o(slot_data)
  );

  ifs_flag_update #(.DW(DW)) i_flags (
    .flags_i(flags_q), .gate_intr_i(intr_q), .flags_o(flags_new)
  );

  always_comb begin
    unique case (form_i)
      FORM_BRK: vec_sel = VEC_BRK;
      FORM_OVF: vec_sel = VEC_OVF;
      default:  vec_sel = imm_i;
    endcase
  end

  assign slot_step   = g32_q ? AW'(4) : AW'(2);
  assign sp_next     = sp_q - slot_step;
  assign last_slot   = err_q ? (slot_q == SLOT_ERR) : (slot_q == SLOT_PTR);
  assign busy_o      = state_q != ST_IDLE;
  assign mem_we_o    = state_q == ST_PUSH;
  assign mem_wide_o  = g32_q;
  assign mem_addr_o  = sp_next;
  assign mem_wdata_o = slot_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      slot_q     <= SLOT_FLAGS;
      g32_q      <= 1'b0;
      intr_q     <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= '0;
      flags_q    <= '0;
      sp_q       <= '0;
      lim_q      <= '0;
      ip_q       <= '0;
      tgt_ip_q   <= '0;
      tgt_lim_q  <= '0;
      cs_q       <= '0;
      tgt_cs_q   <= '0;
      cpl_q      <= '0;
      vector_o   <= '0;
      done_o     <= 1'b0;
      ss_fault_o <= 1'b0;
      gp_fault_o <= 1'b0;
      sp_o       <= '0;
      flags_o    <= '0;
      cs_o       <= '0;
      ip_o       <= '0;
    end else begin
      done_o     <= 1'b0;
      ss_fault_o <= 1'b0;
      gp_fault_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q    <= ST_CHECK;
          slot_q     <= SLOT_FLAGS;
          g32_q      <= gate32_i;
          intr_q     <= gate_intr_i;
          err_q      <= has_err_i;
          err_code_q <= err_code_i;
          flags_q    <= flags_i;
          sp_q       <= sp_i;
          lim_q      <= sp_limit_i;
          ip_q       <= ip_i;
          tgt_ip_q   <= tgt_ip_i;
          tgt_lim_q  <= tgt_limit_i;
          cs_q       <= cs_i;
          tgt_cs_q   <= tgt_cs_i;
          cpl_q      <= cpl_i;
          vector_o   <= vec_sel;
        end
        ST_CHECK: begin
          if (chk_ss || chk_gp) begin
            state_q    <= ST_IDLE;
            done_o     <= 1'b1;
            ss_fault_o <= chk_ss;
            gp_fault_o <= chk_gp;
          end else begin
            state_q <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          sp_q   <= sp_next;
          slot_q <= slot_e'(slot_q + 2'd1);
          if (last_slot) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            sp_o    <= sp_next;
            flags_o <= flags_new;
            cs_o    <= {tgt_cs_q[SW-1:2], cpl_q};
            ip_o    <= g32_q ? tgt_ip_q : {{(AW-16){1'b0}}, tgt_ip_q[15:0]};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          ss_fault_o,
  input logic          gp_fault_o,
  input logic          mem_we_o,
  input logic          mem_wide_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] flags_o
);
  a_r10_one_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ss_fault_o, gp_fault_o}));

  a_r10_fault_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_fault_o || gp_fault_o) |-> done_o);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  a_r2_no_write_before_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !(ss_fault_o || gp_fault_o));

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      mem_addr_o == $past(mem_addr_o) - (mem_wide_o ? AW'(4) : AW'(2)));

  a_r8_flags_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ss_fault_o && !gp_fault_o) |->
      (flags_o[8] == 1'b0 && flags_o[14] == 1'b0 && flags_o[16] == 1'b0 && flags_o[17] == 1'b0));
endmodule

bind int_frame_seq ifs_checker #(.AW(AW), .DW(DW)) i_ifs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .ss_fault_o(ss_fault_o), .gp_fault_o(gp_fault_o), .mem_we_o(mem_we_o),
  .mem_wide_o(mem_wide_o), .mem_addr_o(mem_addr_o), .flags_o(flags_o)
);

// File: tb/test_int_frame_seq.sv
module test_int_frame_seq;
  localparam int PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  form_i = '0;
  logic [7:0]  imm_i = '0;
  logic        gate32_i = 1'b0, gate_intr_i = 1'b0, has_err_i = 1'b0;
  logic [31:0] err_code_i = '0, sp_i = '0, sp_limit_i = '0, flags_i = '0;
  logic [15:0] cs_i = '0, tgt_cs_i = '0;
  logic [31:0] ip_i = '0, tgt_ip_i = '0, tgt_limit_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        busy_o, done_o, ss_fault_o, gp_fault_o, mem_we_o, mem_wide_o;
  logic [7:0]  vector_o;
  logic [31:0] mem_addr_o, mem_wdata_o, sp_o, flags_o, ip_o;
  logic [15:0] cs_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  int_frame_seq i_int_frame_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input bit g, input bit e, input bit it, input logic [1:0] f,
                         input bit short_room, input bit over, input bit hold, input int n_iter);
    logic [31:0] wa[4], wd[4];
    bit          ww[4];
    int          nw = 0, cyc = 1, slots, slot_b, need;
    logic [31:0] pre_sp, pre_fl, pre_ip, exp_fl, ed[4], mask;
    logic [15:0] pre_cs;
    logic [7:0]  exp_vec;
    bit          busy_ok = 1;
    slot_b = g ? 4 : 2;
    slots  = 3 + int'(e);
    need   = slot_b * slots;
    pre_sp = sp_o; pre_fl = flags_o; pre_ip = ip_o; pre_cs = cs_o;
    gate32_i = g; has_err_i = e; gate_intr_i = it; form_i = f;
    imm_i = 8'h40 + 8'(n_iter);
    err_code_i = 32'hE000_0000 + 32'(n_iter * 7);
    sp_i = 32'h0000_8000 + 32'(n_iter * 64);
    sp_limit_i = sp_i - 32'(need) + (short_room ? 32'd1 : 32'd0);
    flags_i = 32'h0003_C3A5 ^ 32'(n_iter << 4);
    cs_i = 16'h1230 + 16'(n_iter);
    ip_i = 32'hABCD_0000 + 32'(n_iter * 3);
    tgt_cs_i = 16'h5673 + 16'(n_iter << 2);
    tgt_ip_i = 32'h0001_2340 + 32'(n_iter);
    tgt_limit_i = over ? tgt_ip_i - 32'd1 : tgt_ip_i;
    cpl_i = 2'(n_iter);
    exp_vec = (f == 2'd1) ? 8'd3 : (f == 2'd2) ? 8'd4 : imm_i;
    ed[0] = flags_i; ed[1] = {16'h0, cs_i}; ed[2] = ip_i; ed[3] = err_code_i;
    req_i = 1'b1;
    @(negedge clk_i);
    if (hold) begin
      imm_i = ~imm_i; sp_i = 32'h0; flags_i = '0; cs_i = 16'hFFFF; err_code_i = 32'h1;
    end else req_i = 1'b0;
    while (!done_o && cyc < 20) begin
      if (!busy_o) busy_ok = 0;
      if (mem_we_o && nw < 4) begin
        wa[nw] = mem_addr_o; wd[nw] = mem_wdata_o; ww[nw] = mem_wide_o;
      end
      if (mem_we_o) nw++;
      @(negedge clk_i);
      cyc++;
    end
    req_i = 1'b0;
    chk("R10 busy until done", 32'(busy_ok), 32'd1);
    chk("R1 vector", 32'(vector_o), 32'(exp_vec));
    if (short_room) begin
      chk(g ? "R2 room fault" : "R3 room fault", {ss_fault_o, gp_fault_o, done_o}, 3'b101);
      chk("R2 no writes", 32'(nw), 32'd0);
      chk("R10 fault latency", 32'(cyc), 32'd2);
      chk("R2 sp kept", sp_o, pre_sp);
      chk("R2 flags kept", flags_o, pre_fl);
      chk("R2 ip kept", ip_o, pre_ip);
      chk("R2 cs kept", 32'(cs_o), 32'(pre_cs));
    end else if (over) begin
      chk("R9 gp fault", {ss_fault_o, gp_fault_o, done_o}, 3'b011);
      chk("R9 no writes", 32'(nw), 32'd0);
      chk("R10 fault latency", 32'(cyc), 32'd2);
      chk("R9 sp kept", sp_o, pre_sp);
    end else begin
      chk(g ? "R2 exact room ok" : "R3 exact room ok", {ss_fault_o, gp_fault_o, done_o}, 3'b001);
      chk("R10 success latency", 32'(cyc), 32'(slots + 2));
      chk("R4 write count", 32'(nw), 32'(slots));
      for (int k = 0; k < slots && k < nw && k < 4; k++) begin
        mask = g ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        chk("R4 write addr", wa[k], sp_i_saved(n_iter) - 32'(slot_b * (k + 1)));
        chk(g ? "R5 write data" : "R6 write data", wd[k], ed[k] & mask);
        chk(g ? "R5 wide" : "R6 narrow", 32'(ww[k]), 32'(g));
      end
      exp_fl = ed[0] & ~(32'h0003_4100 | (it ? 32'h0000_0200 : 32'h0));
      chk("R8 flags", flags_o, exp_fl);
      chk("R7 sp", sp_o, sp_i_saved(n_iter) - 32'(need));
      chk("R7 ip", ip_o, g ? (32'h0001_2340 + 32'(n_iter)) : ((32'h0001_2340 + 32'(n_iter)) & 32'hFFFF));
      chk("R7 cs", 32'(cs_o), 32'({tgt_cs_saved(n_iter)[15:2], 2'(n_iter)}));
    end
    @(negedge clk_i);
    chk("R10 done one cycle", 32'(done_o), 32'd0);
    chk("R11 idle after run", 32'(busy_o), 32'd0);
  endtask

  function automatic logic [31:0] sp_i_saved(input int n);
    return 32'h0000_8000 + 32'(n * 64);
  endfunction

  function automatic logic [15:0] tgt_cs_saved(input int n);
    return 16'h5673 + 16'(n << 2);
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk_i);
    chk("R10 reset busy", 32'(busy_o), 32'd0);
    chk("R10 reset done", {done_o, ss_fault_o, gp_fault_o, mem_we_o}, 4'b0000);
    chk("R7 reset sp", sp_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 2; e++)
        for (int it = 0; it < 2; it++)
          for (int f = 0; f < 3; f++)
            for (int s = 0; s < 2; s++)
              for (int o = 0; o < 2; o++) begin
                run_one(g[0], e[0], it[0], 2'(f), s[0], o[0], 1'b0, n);
                n++;
              end
    // R11: request held high and snapshot changed while busy
    run_one(1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, n);
    n++;
    run_one(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, n);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule